// File: doc/BRIEF.md
# UDP Control Packet Decoder

The decoder watches a stream of 32-bit words that carry IPv4/UDP packets. A start-of-packet flag marks the first word of each packet. Packets of one fixed, minimal shape are accepted as control packets:

- a 20-byte IPv4 header with no options and a total length of 40 bytes;
- an 8-byte UDP header aimed at one configured destination port;
- a three-word command payload: a tag word, an address word and a data word.

Each accepted packet becomes one command for the processor memory controller:

- a write of one 32-bit word to a byte address;
- a start;
- a halt.

The command is presented on a one-cycle strobe, together with an opcode, an address and the write data. Anything that does not match the expected header is discarded silently. Checksums are not examined.

A control state machine tracks each packet, with a header word index kept beside it. Its states are:

- `ST_IDLE`: waiting for a packet.
- `ST_HEADER`: checking header words 1 to 7 against the expected values.
- `ST_ADDR`: capturing the address word.
- `ST_DATA`: capturing the data word and issuing the command.
- `ST_DROP`: ignoring the rest of a rejected packet.

Its transitions are:

- Any valid word flagged start-of-packet moves to `ST_HEADER` with index 1 if it equals 0x45000028, and to `ST_DROP` otherwise. This happens from every state.
- In `ST_HEADER`, a mismatching word goes to `ST_DROP`. A matching word advances the index. The matching command tag (index 7) goes to `ST_ADDR`.
- `ST_ADDR` goes to `ST_DATA` on the next valid word.
- `ST_DATA` goes to `ST_IDLE` on the next valid word and fires the strobe.
- `ST_IDLE` and `ST_DROP` stay where they are until a start-of-packet word arrives.

Top module: `ctl_pkt_decoder`

## Requirements
- R1: After reset `cmd_strobe` is 0 and `cmd_op` is 0 (no command).
- R2: A valid ten-word control packet fires exactly one `cmd_strobe`, in the cycle after the data word (word 9) is accepted. The strobe carries `cmd_op`=2'b01 (write), `cmd_addr` equal to word 8 and `cmd_wdata` equal to word 9.
- R3: When word 8 is 0x00000006 and word 9 is 0, the command is a start, with `cmd_op`=2'b10.
- R4: When word 8 is 0x00000007 and word 9 is 0, the command is a halt, with `cmd_op`=2'b11. Address 0x00000006 with nonzero data is a plain write.
- R5: A packet whose word 0 is not 0x45000028 (wrong version, header size or total length) produces no strobe.
- R6: A packet whose word 2 bits [31:16] differ from 0x4011 (TTL 0x40, protocol 0x11 = UDP) produces no strobe.
- R7: A packet whose word 5 bits [15:0] differ from the destination port 0xBEEF produces no strobe. Word 5 bits [31:16] (source port) are ignored.
- R8: A packet whose word 6 bits [31:16] differ from 0x0014 (UDP length 20), or whose word 7 differs from 0x74090000, produces no strobe.
- R9: `cmd_strobe` is never high for two cycles in a row.
- R10: A start-of-packet word arriving inside a packet abandons that packet. The truncated packet yields no command, and the new packet is decoded normally.
- R11: Cycles with `in_valid` low may appear between words of a packet without effect. Valid words without start-of-packet outside a packet are ignored.
- R12: `cmd_op`, `cmd_addr` and `cmd_wdata` keep their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | `in_word` carries a stream word this cycle |
| in_sop | input | 1 | The word is the first of a packet (meaningful with `in_valid`) |
| in_word | input | 32 | Stream word |
| cmd_strobe | output | 1 | One-cycle command pulse |
| cmd_op | output | 2 | 00 none, 01 write, 10 start, 11 halt |
| cmd_addr | output | 32 | Byte address of a write |
| cmd_wdata | output | 32 | Data of a write |

## Verification
The assertions assume that `in_sop` is only meaningful together with `in_valid`. They also assume that a packet's words are presented in order, with no word repeated. The bench keeps within this: `in_sop` is raised only on the first word it drives for each packet, and it is cleared whenever `in_valid` is low. Idle gaps inside a packet are placed only between whole words, so each word is seen exactly once by the decoder.

// File: rtl/ctl_pkt_pkg.sv
package ctl_pkt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HEADER = 3'd1,
        ST_ADDR   = 3'd2,
        ST_DATA   = 3'd3,
        ST_DROP   = 3'd4
    } dec_state_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_START = 2'b10,
        OP_HALT  = 2'b11
    } cmd_op_t;

    // first packet word: IPv4, five-word header, 40 bytes total
    localparam logic [31:0] HDR_FIRST_WORD = 32'h4500_0028;
    // TTL and protocol field expected in header word 2
    localparam logic [15:0] HDR_TTL_PROTO  = 16'h4011;
    // UDP length field expected in header word 6
    localparam logic [15:0] HDR_UDP_LEN    = 16'h0014;

endpackage

// File: rtl/hdr_word_check.sv
module hdr_word_check
    import ctl_pkt_pkg::*;
#(
    parameter int          HDR_WORDS = 8,
    parameter logic [15:0] DEST_PORT = 16'hBEEF,
    parameter logic [31:0] CMD_TAG   = 32'h7409_0000,
    localparam int         IDX_W     = $clog2(HDR_WORDS)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      word,
    output logic             ok
);

    always_comb begin
        case (idx)
            IDX_W'(0): ok = (word == HDR_FIRST_WORD);
            IDX_W'(2): ok = (word[31:16] == HDR_TTL_PROTO);
            IDX_W'(5): ok = (word[15:0] == DEST_PORT);
            IDX_W'(6): ok = (word[31:16] == HDR_UDP_LEN);
            IDX_W'(7): ok = (word == CMD_TAG);
            default:   ok = 1'b1;   // identification, addresses: not checked
        endcase
    end

endmodule

// File: rtl/cmd_classify.sv
module cmd_classify
    import ctl_pkt_pkg::*;
#(
    parameter logic [31:0] START_CODE = 32'h0000_0006,
    parameter logic [31:0] HALT_CODE  = 32'h0000_0007
) (
    input  logic [31:0] addr,
    input  logic [31:0] data,
    output cmd_op_t     op
);

    logic data_zero;

    assign data_zero = (data == 32'h0);

    always_comb begin
        if (data_zero && addr == START_CODE)
            op = OP_START;
        else if (data_zero && addr == HALT_CODE)
            op = OP_HALT;
        else
            op = OP_WRITE;
    end

endmodule

// File: rtl/ctl_pkt_decoder.sv
module ctl_pkt_decoder
    import ctl_pkt_pkg::*;
#(
    parameter int          HDR_WORDS  = 8,
    parameter logic [15:0] DEST_PORT  = 16'hBEEF,
    parameter logic [31:0] CMD_TAG    = 32'h7409_0000,
    parameter logic [31:0] START_CODE = 32'h0000_0006,
    parameter logic [31:0] HALT_CODE  = 32'h0000_0007
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic [31:0] in_word,
    output logic        cmd_strobe,
    output logic [1:0]  cmd_op,
    output logic [31:0] cmd_addr,
    output logic [31:0] cmd_wdata
);

    localparam int IDX_W = $clog2(HDR_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_WORDS - 1);

    dec_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [31:0]      addr_q, addr_d;
    logic [IDX_W-1:0] chk_idx;
    logic             hdr_ok;
    cmd_op_t          class_op;
    logic             fire;

    // word 0 is always checked at index 0, whatever the state
    assign chk_idx = in_sop ? '0 : idx_q;

    hdr_word_check #(
        .HDR_WORDS (HDR_WORDS),
        .DEST_PORT (DEST_PORT),
        .CMD_TAG   (CMD_TAG)
    ) u_hdr (
        .idx  (chk_idx),
        .word (in_word),
        .ok   (hdr_ok)
    );

    cmd_classify #(
        .START_CODE (START_CODE),
        .HALT_CODE  (HALT_CODE)
    ) u_class (
        .addr (addr_q),
        .data (in_word),
        .op   (class_op)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        addr_d  = addr_q;
        if (in_valid) begin
            if (in_sop) begin
                idx_d   = IDX_W'(1);
                state_d = hdr_ok ? ST_HEADER : ST_DROP;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_DROP: ;
                    ST_HEADER: begin
                        if (!hdr_ok)
                            state_d = ST_DROP;
                        else if (idx_q == LAST_IDX)
                            state_d = ST_ADDR;
                        else
                            idx_d = idx_q + IDX_W'(1);
                    end
                    ST_ADDR: begin
                        addr_d  = in_word;
                        state_d = ST_DATA;
                    end
                    ST_DATA: state_d = ST_IDLE;
                endcase
            end
        end
    end

    assign fire = in_valid && !in_sop && (state_q == ST_DATA);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            addr_q  <= addr_d;
        end
    end

    // command outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_strobe <= 1'b0;
            cmd_op     <= OP_NONE;
            cmd_addr   <= '0;
            cmd_wdata  <= '0;
        end else begin
            cmd_strobe <= fire;
            if (fire) begin
                cmd_op    <= class_op;
                cmd_addr  <= addr_q;
                cmd_wdata <= in_word;
            end
        end
    end

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    // R2
    strobe_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> (state_q == ST_IDLE) && (cmd_op != OP_NONE));

    // R3
    start_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_op == OP_START) |-> (cmd_addr == START_CODE && cmd_wdata == 32'h0));

    // R5
    bad_first_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && in_word != HDR_FIRST_WORD) |=> (state_q == ST_DROP));

    // R10
    sop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |=> !cmd_strobe && (state_q == ST_HEADER || state_q == ST_DROP));

    // R12
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe |=> $stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_op) || cmd_strobe);

endmodule

// File: tb/ctl_pkt_decoder_tb.sv
`timescale 1ns/1ps
module ctl_pkt_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [31:0] in_word = '0;
    logic        cmd_strobe;
    logic [1:0]  cmd_op;
    logic [31:0] cmd_addr;
    logic [31:0] cmd_wdata;

    int checks = 0;
    int errors = 0;
    int strobe_cnt = 0;
    bit done = 0;
    logic [31:0] pkt [10];

    always #2.5 clk = ~clk;

    ctl_pkt_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_word(in_word), .cmd_strobe(cmd_strobe), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
    );

    always @(negedge clk) if (rst_n && cmd_strobe) strobe_cnt++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic build(input logic [31:0] a, input logic [31:0] d);
        pkt[0] = 32'h4500_0028; pkt[1] = 32'h0000_0000; pkt[2] = 32'h4011_0000;
        pkt[3] = 32'h7f00_0001; pkt[4] = 32'h807f_0001; pkt[5] = 32'h0000_beef;
        pkt[6] = 32'h0014_0000; pkt[7] = 32'h7409_0000; pkt[8] = a; pkt[9] = d;
    endtask

    task automatic send_word(input bit sop, input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1; in_sop = sop; in_word = w;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_word = 32'hx5a5_a5a5;
        end
    endtask

    task automatic send_pkt(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            send_word(i == 0, pkt[i]);
            if (gap > 0 && i < n - 1) idle(gap);
        end
    endtask

    // packet already built; expect one command right after the data word
    task automatic expect_cmd(input string tag, input logic [1:0] op, input int gap);
        int c0 = strobe_cnt;
        send_pkt(10, gap);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
        #1;
        chk(cmd_strobe === 1'b1, {tag, " strobe"}, 32'(cmd_strobe), 32'd1);
        chk(cmd_op === op, {tag, " op"}, 32'(cmd_op), 32'(op));
        chk(cmd_addr === pkt[8], {tag, " addr"}, cmd_addr, pkt[8]);
        chk(cmd_wdata === pkt[9], {tag, " data"}, cmd_wdata, pkt[9]);
        @(negedge clk); #1;
        chk(cmd_strobe === 1'b0, "R9 strobe low next cycle", 32'(cmd_strobe), 32'd0);
        idle(2); #1;
        chk(strobe_cnt - c0 == 1, "R9 one strobe per packet", 32'(strobe_cnt - c0), 32'd1);
    endtask

    task automatic expect_drop(input string tag);
        int c0 = strobe_cnt;
        logic [31:0] a0 = cmd_addr;
        logic [31:0] d0 = cmd_wdata;
        send_pkt(10, 0);
        idle(3); #1;
        chk(strobe_cnt == c0, tag, 32'(strobe_cnt - c0), 32'd0);
        chk(cmd_addr === a0 && cmd_wdata === d0, "R12 fields held", cmd_addr, a0);
    endtask

    task automatic t_reset;
        #1;
        chk(cmd_strobe === 1'b0, "R1 strobe", 32'(cmd_strobe), 32'd0);
        chk(cmd_op === 2'b00, "R1 op", 32'(cmd_op), 32'd0);
    endtask

    task automatic t_write;
        build(32'h4000_0000, 32'h0000_000b);
        expect_cmd("R2 write", 2'b01, 0);
        build(32'h0000_1000, 32'hdead_beef);
        expect_cmd("R2 write 2", 2'b01, 0);
    endtask

    task automatic t_gaps;
        send_word(1'b0, 32'h4500_0028);   // stray word, no sop: ignored
        send_word(1'b0, 32'h1234_5678);
        idle(2); #1;
        chk(cmd_strobe === 1'b0, "R11 stray words", 32'(cmd_strobe), 32'd0);
        build(32'h0000_0010, 32'hcafe_f00d);
        expect_cmd("R11 gapped packet", 2'b01, 2);
    endtask

    task automatic t_start_halt;
        build(32'h0000_0006, 32'h0);
        expect_cmd("R3 start", 2'b10, 0);
        build(32'h0000_0007, 32'h0);
        expect_cmd("R4 halt", 2'b11, 0);
        build(32'h0000_0006, 32'h0000_0005);
        expect_cmd("R4 addr 6 nonzero data write", 2'b01, 0);
    endtask

    task automatic t_drops;
        build(32'h2000_0000, 32'h1111_1111);
        pkt[0] = 32'h4600_0028; expect_drop("R5 bad version");
        build(32'h2000_0000, 32'h1111_1111);
        pkt[2] = 32'h4006_0000; expect_drop("R6 bad protocol");
        build(32'h2000_0000, 32'h1111_1111);
        pkt[2] = 32'h3f11_0000; expect_drop("R6 bad ttl");
        build(32'h2000_0000, 32'h1111_1111);
        pkt[5] = 32'h0000_beee; expect_drop("R7 bad port");
        build(32'h2000_0000, 32'h1111_1111);
        pkt[6] = 32'h0015_0000; expect_drop("R8 bad length");
        build(32'h2000_0000, 32'h1111_1111);
        pkt[7] = 32'h7409_0001; expect_drop("R8 bad tag");
        build(32'h2000_0004, 32'h2222_2222);
        pkt[5] = 32'h1234_beef;
        expect_cmd("R7 source port ignored", 2'b01, 0);
    endtask

    task automatic t_trunc;
        int c0 = strobe_cnt;
        build(32'h3000_0000, 32'h3333_3333);
        send_pkt(9, 0);                    // data word never sent
        build(32'h3000_0008, 32'h4444_4444);
        expect_cmd("R10 restart packet", 2'b01, 0);
        chk(strobe_cnt - c0 == 1, "R10 truncated gives none", 32'(strobe_cnt - c0), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_gaps();
        t_start_halt();
        t_drops();
        t_trunc();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule